// File: doc/BRIEF.md
# Color Lookup Table with Sequenced Register Write Port

This block holds a 256-entry color palette and exposes it through two paths. A bus master programs it through a 16-byte register window. One word selects the palette slot. Another word takes color components. Every write carries its payload in the most significant byte of the 32-bit bus word. Three back-to-back data writes fill the red, green and blue values of the selected slot in that order. The slot pointer then moves to the next entry, so firmware can stream a whole palette after a single pointer write.

The second path is a combinational lookup port for a display pipeline. It takes an 8-bit pixel code and returns the 24-bit color stored for it, with red in the upper byte and blue in the lower byte. Register reads carry no information and always return zero.

Top module: `clut_ramdac`

## Requirements
- R1: After reset every palette entry reads as 0x000000 on the lookup port, except entry 255, which reads as 0xFFFFFF. The slot pointer is 0 and the component step is red.
- R2: A write with bus_addr[3:2] = 0 loads the slot pointer from bus_wdata[31:24]. It also returns the component step to red. bus_wdata[23:0] has no effect.
- R3: Writes with bus_addr[3:2] = 1 store bus_wdata[31:24] into the component of the pointed slot selected by the step. The first such write goes to red, the second to green and the third to blue.
- R4: The write that stores blue advances the slot pointer by one, wrapping from 255 to 0, and returns the step to red.
- R5: A pointer write in the middle of a red/green/blue sequence discards the partial progress. The next data write goes to red of the newly pointed slot. The component already stored stays in place.
- R6: Writes with bus_addr[3:2] = 2 or 3 change neither the palette, the slot pointer nor the component step.
- R7: Only bus_addr[3:2] is decoded. Address bits above bit 3, and bits [1:0], do not affect which register is written.
- R8: bus_rdata is zero at all times.
- R9: lut_rgb equals {red, green, blue} of entry lut_idx, combinationally from lut_idx. A palette write is visible there from the clock edge that performs it.
- R10: While bus_we is low, the palette, slot pointer and step hold, whatever the other bus inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 12 | Byte address; only the 16-byte window offset is decoded |
| bus_wdata | input | 32 | Write data; payload in bits [31:24] |
| bus_rdata | output | 32 | Read data, always zero |
| lut_idx | input | 8 | Pixel code to look up |
| lut_rgb | output | 24 | Color of entry lut_idx as {R,G,B} |

## Verification
The slot pointer and the component step are hidden. A fault in either shows up as a value landing in the wrong byte or the wrong entry. The effect appears on lut_rgb in the cycle after the faulty write, but only for the entry being looked at. The bench therefore reads back the intended entry and its neighbours after each sequence, and it continues sequences across a wrap and across aborted triplets. A step counter off by one, for example, corrupts the colour of every following entry. A pointer that fails to advance makes a later triplet overwrite the previous one.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        STEP_RED = 2'd0,
        STEP_GRN = 2'd1,
        STEP_BLU = 2'd2
    } step_e;

    localparam int NUM_COMP = 3;

endpackage

// File: rtl/clut_decode.sv
module clut_decode #(
    parameter int ADDR_W    = 12,
    parameter int WIN_BYTES = 16
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              idx_wr,
    output logic              data_wr
);
    localparam int OFF_W = $clog2(WIN_BYTES);
    localparam int SEL_W = OFF_W - 2;

    logic [SEL_W-1:0] word_sel;
    logic             unused_addr;

    // Word select inside the window; the byte lane and upper bits are dropped.
    assign word_sel    = bus_addr[OFF_W-1:2];
    assign unused_addr = ^bus_addr;

    assign idx_wr  = bus_we && (word_sel == SEL_W'(0));
    assign data_wr = bus_we && (word_sel == SEL_W'(1));
endmodule

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              data_wr,
    input  logic [IDX_W-1:0]  idx_val,
    output logic [IDX_W-1:0]  idx_q,
    output step_e             step_q,
    output logic [NUM_COMP-1:0] comp_we
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        step_e            step;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (idx_wr) begin
            st_d.idx  = idx_val;
            st_d.step = STEP_RED;
        end else if (data_wr) begin
            unique case (st_q.step)
                STEP_RED: st_d.step = STEP_GRN;
                STEP_GRN: st_d.step = STEP_BLU;
                default: begin
                    st_d.step = STEP_RED;
                    st_d.idx  = st_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, step: STEP_RED};
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_q  = st_q.idx;
    assign step_q = st_q.step;

    // Component write strobes: red is bit 0, green bit 1, blue bit 2.
    assign comp_we[0] = data_wr && (st_q.step == STEP_RED);
    assign comp_we[1] = data_wr && (st_q.step == STEP_GRN);
    assign comp_we[2] = data_wr && (st_q.step == STEP_BLU);
endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
    parameter int              IDX_W    = 8,
    parameter int              COMP_W   = 8,
    parameter logic [COMP_W-1:0] LAST_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [COMP_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [COMP_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [COMP_W-1:0] mem_d [DEPTH];
    logic [COMP_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= (i == DEPTH - 1) ? LAST_RST : '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/clut_ramdac.sv
module clut_ramdac
    import clut_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BUS_W     = 32,
    parameter int IDX_W     = 8,
    parameter int COMP_W    = 8,
    parameter int WIN_BYTES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    input  logic [IDX_W-1:0]           lut_idx,
    output logic [NUM_COMP*COMP_W-1:0] lut_rgb
);
    logic                idx_wr;
    logic                data_wr;
    logic [IDX_W-1:0]    idx_q;
    step_e               step_q;
    logic [NUM_COMP-1:0] comp_we;
    logic [IDX_W-1:0]    idx_val;
    logic [COMP_W-1:0]   comp_val;
    logic                unused_wdata;

    assign idx_val      = bus_wdata[BUS_W-1 -: IDX_W];
    assign comp_val     = bus_wdata[BUS_W-1 -: COMP_W];
    assign unused_wdata = ^bus_wdata;
    assign bus_rdata    = '0;

    clut_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BYTES(WIN_BYTES)
    ) u_decode (
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .idx_wr  (idx_wr),
        .data_wr (data_wr)
    );

    clut_seq #(
        .IDX_W (IDX_W),
        .COMP_W(COMP_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .data_wr(data_wr),
        .idx_val(idx_val),
        .idx_q  (idx_q),
        .step_q (step_q),
        .comp_we(comp_we)
    );

    // Bank 0 is red (top byte of lut_rgb), bank 2 is blue (bottom byte).
    for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
        clut_bank #(
            .IDX_W   (IDX_W),
            .COMP_W  (COMP_W),
            .LAST_RST({COMP_W{1'b1}})
        ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (comp_we[c]),
            .waddr(idx_q),
            .wdata(comp_val),
            .raddr(lut_idx),
            .rdata(lut_rgb[(NUM_COMP-1-c)*COMP_W +: COMP_W])
        );
    end
endmodule

// File: rtl/clut_ramdac_chk.sv
module clut_ramdac_chk #(
    parameter int ADDR_W    = 12,
    parameter int BUS_W     = 32,
    parameter int IDX_W     = 8,
    parameter int COMP_W    = 8,
    parameter int WIN_BYTES = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [BUS_W-1:0]      bus_wdata,
    input logic [IDX_W-1:0]      lut_idx,
    input logic [3*COMP_W-1:0]   lut_rgb,
    input logic [IDX_W-1:0]      idx_q,
    input logic [1:0]            step_q
);
    localparam int OFF_W = $clog2(WIN_BYTES);
    localparam int SEL_W = OFF_W - 2;

    logic [SEL_W-1:0] sel;
    logic             wr_idx, wr_dat, wr_rsv;
    assign sel    = bus_addr[OFF_W-1:2];
    assign wr_idx = bus_we && sel == SEL_W'(0);
    assign wr_dat = bus_we && sel == SEL_W'(1);
    assign wr_rsv = bus_we && sel > SEL_W'(1);

    p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idx |=> (idx_q == $past(bus_wdata[BUS_W-1 -: IDX_W]) && step_q == 2'd0));

    p_red_to_grn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && step_q == 2'd0) |=> step_q == 2'd1 && $stable(idx_q));

    p_grn_to_blu_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && step_q == 2'd1) |=> step_q == 2'd2 && $stable(idx_q));

    p_red_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && step_q == 2'd0 && lut_idx == idx_q) |=>
            ($stable(lut_idx) -> lut_rgb[3*COMP_W-1 -: COMP_W] == $past(bus_wdata[BUS_W-1 -: COMP_W])));

    p_blue_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && step_q == 2'd2) |=> (step_q == 2'd0 && idx_q == IDX_W'($past(idx_q) + 1'b1)));

    p_rsv_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rsv |=> ($stable(idx_q) && $stable(step_q)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(idx_q) && $stable(step_q)));

    p_step_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_q != 2'd3);
endmodule

bind clut_ramdac clut_ramdac_chk #(
    .ADDR_W   (ADDR_W),
    .BUS_W    (BUS_W),
    .IDX_W    (IDX_W),
    .COMP_W   (COMP_W),
    .WIN_BYTES(WIN_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .lut_idx  (lut_idx),
    .lut_rgb  (lut_rgb),
    .idx_q    (idx_q),
    .step_q   (step_q)
);

// File: tb/clut_ramdac_tb.sv
module clut_ramdac_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lut_idx = '0;
    logic [23:0] lut_rgb;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [7:0]  idx;
        logic [23:0] rgb;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    bit   mon_busy = 1'b0;

    // Reference model
    logic [7:0] r_m [256];
    logic [7:0] g_m [256];
    logic [7:0] b_m [256];
    logic [7:0] idx_m;
    int         step_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    clut_ramdac u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .lut_idx  (lut_idx),
        .lut_rgb  (lut_rgb)
    );

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            r_m[i] = (i == 255) ? 8'hFF : 8'h00;
            g_m[i] = (i == 255) ? 8'hFF : 8'h00;
            b_m[i] = (i == 255) ? 8'hFF : 8'h00;
        end
        idx_m  = 8'd0;
        step_m = 0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        case (a[3:2])
            2'd0: begin idx_m = d[31:24]; step_m = 0; end
            2'd1: begin
                if (step_m == 0) begin r_m[idx_m] = d[31:24]; step_m = 1; end
                else if (step_m == 1) begin g_m[idx_m] = d[31:24]; step_m = 2; end
                else begin b_m[idx_m] = d[31:24]; step_m = 0; idx_m = idx_m + 8'd1; end
            end
            default: ;
        endcase
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = 32'hDEAD_BEEF;
        bus_addr  = 12'hFFF;
    endtask

    task automatic expect_entry(input logic [7:0] i, input string tag);
        exp_t e;
        e.idx = i;
        e.rgb = {r_m[i], g_m[i], b_m[i]};
        e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    task automatic check_rdata(input string tag);
        #1;
        n_tests++;
        if (bus_rdata !== 32'h0) begin
            n_fail++;
            $display("FAIL %s bus_rdata actual=%h expected=%h", tag, bus_rdata, 32'h0);
        end
    endtask

    // Monitor: pops expected items, drives the lookup port, compares.
    initial begin
        exp_t e;
        forever begin
            wait (exp_q.size() > 0);
            mon_busy = 1'b1;
            @(negedge clk);
            e = exp_q.pop_front();
            lut_idx = e.idx;
            #1;
            n_tests++;
            if (lut_rgb !== e.rgb) begin
                n_fail++;
                $display("FAIL %s entry %0d actual=%h expected=%h", e.tag, e.idx, lut_rgb, e.rgb);
            end
            mon_busy = 1'b0;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_tests++;
        n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        expect_entry(8'd0,   "R1");
        expect_entry(8'd1,   "R1");
        expect_entry(8'd128, "R1");
        expect_entry(8'd254, "R1");
        expect_entry(8'd255, "R1");
        check_rdata("R8");

        // R1: pointer 0 and step red after reset
        bus_write(12'h004, 32'h1100_0000);
        bus_write(12'h004, 32'h2200_0000);
        bus_write(12'h004, 32'h3300_0000);
        expect_entry(8'd0, "R1");

        // R2/R3/R9: pointer write with junk low bits, then a triplet
        bus_write(12'h000, 32'h10AB_CDEF);
        bus_write(12'h004, 32'hAA12_3456);
        bus_write(12'h004, 32'hBB00_00FF);
        check_rdata("R8");
        bus_write(12'h004, 32'hCCFF_FFFF);
        expect_entry(8'h10, "R3");
        expect_entry(8'h0F, "R9");

        // R4: auto advance
        bus_write(12'h004, 32'h0100_0000);
        bus_write(12'h004, 32'h0200_0000);
        bus_write(12'h004, 32'h0300_0000);
        expect_entry(8'h11, "R4");
        expect_entry(8'h10, "R4");

        // R5: abort partial triplet
        bus_write(12'h000, 32'h2000_0000);
        bus_write(12'h004, 32'h5500_0000);
        bus_write(12'h000, 32'h2100_0000);
        bus_write(12'h004, 32'h6600_0000);
        bus_write(12'h004, 32'h7700_0000);
        bus_write(12'h004, 32'h8800_0000);
        expect_entry(8'h20, "R5");
        expect_entry(8'h21, "R5");

        // R4: wrap 255 -> 0
        bus_write(12'h000, 32'hFF00_0000);
        bus_write(12'h004, 32'h0100_0000);
        bus_write(12'h004, 32'h0200_0000);
        bus_write(12'h004, 32'h0300_0000);
        expect_entry(8'hFF, "R4");
        bus_write(12'h004, 32'h0400_0000);
        bus_write(12'h004, 32'h0500_0000);
        bus_write(12'h004, 32'h0600_0000);
        expect_entry(8'h00, "R4");
        expect_entry(8'h01, "R4");

        // R6: reserved words ignored mid-sequence
        bus_write(12'h000, 32'h3000_0000);
        bus_write(12'h004, 32'h0900_0000);
        bus_write(12'h008, 32'h4400_0000);
        bus_write(12'h00C, 32'h4500_0000);
        bus_write(12'h004, 32'h0A00_0000);
        bus_write(12'h008, 32'h4600_0000);
        bus_write(12'h004, 32'h0B00_0000);
        expect_entry(8'h30, "R6");
        expect_entry(8'h44, "R6");
        expect_entry(8'h45, "R6");
        expect_entry(8'h31, "R6");

        // R7: aliasing of upper and low address bits
        bus_write(12'h403, 32'h4000_0000);
        bus_write(12'h7F5, 32'hA100_0000);
        bus_write(12'h116, 32'hA200_0000);
        bus_write(12'hFF7, 32'hA300_0000);
        expect_entry(8'h40, "R7");
        bus_write(12'hFF8, 32'h5000_0000);
        bus_write(12'h004, 32'hB100_0000);
        expect_entry(8'h41, "R7");
        expect_entry(8'h50, "R7");

        // R10: idle bus activity without strobe
        bus_write(12'h000, 32'h6000_0000);
        bus_write(12'h004, 32'h1200_0000);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            bus_addr  = 12'(k * 4);
            bus_wdata = {8'(8'h70 + k), 24'h0};
        end
        @(negedge clk);
        bus_addr = 12'h0;
        bus_write(12'h004, 32'h3400_0000);
        bus_write(12'h004, 32'h5600_0000);
        expect_entry(8'h60, "R10");
        expect_entry(8'h70, "R10");
        expect_entry(8'h61, "R10");
        check_rdata("R8");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule